// File: doc/BRIEF.md
# Three-Stage Pipelined Set-Associative Cache Read Path

This block is the read side of a set-associative level-1 cache. It takes one lookup address per cycle and splits the work over three pipeline stages. The first stage launches the tag-array read for all ways of the selected set. The second stage compares each stored tag with the address tag and registers a one-hot hit vector. The third stage uses that vector to steer the matching way's data word to the result. The data arrays of every way are read before the hit way is known. A build-time choice places that read in either the first or the second stage, and the results are the same in both cases. A second build-time choice folds compare and way select into one stage, which gives a two-cycle pipeline.

A lookup address is `{tag, set}`: the low `$clog2(NUM_SETS)` bits pick the set and the upper bits form the tag. Tag arrays, per-way valid bits and data arrays are held inside the block. A fill port writes one tag, one valid bit and one data word into a chosen set and way. A stall input freezes the whole pipeline.

Top module: `pipelined_cache_lookup`

## Requirements
- R1: A valid lookup returns `res_hit`=1 and that way's data word when some way of set `lk_addr[IDX_W-1:0]` holds the tag `lk_addr[ADDR_W-1:IDX_W]` with its valid bit set; otherwise `res_hit`=0.
- R2: A new lookup is accepted every non-stalled cycle. Its result appears on `res_valid` after exactly 3 clock edges in three-stage mode (`TWO_STAGE`=0) and after exactly 2 in two-stage mode (`TWO_STAGE`=1).
- R3: When `res_valid`=1 and `res_hit`=0, `res_data` is zero. When `res_valid`=0, both `res_hit` and `res_data` are zero.
- R4: Results are identical whether the data arrays are read in stage 1 (`DATA_LAUNCH`=LAUNCH_S1) or in stage 2 (LAUNCH_S2).
- R5: While `stall`=1, every pipeline register and every result output holds its value and no array is read. A lookup presented during a stalled cycle is dropped.
- R6: A fill with `fill_en`=1 writes `fill_tag`, `fill_vld` and `fill_data` into set `fill_set`, way `fill_way`. A lookup in any later cycle sees the new contents.
- R7: A lookup and a fill to the same set in the same cycle returns the contents from before the fill.
- R8: A fill presented while `stall`=1 is ignored and changes no array contents.
- R9: Reset (`rst_n`=0) clears all valid bits, so every later lookup misses until a fill. It also clears all pipeline valid flags, so `res_valid`, `res_hit` and `res_data` are zero.
- R10: A fill with `fill_vld`=0 invalidates that way. At most one way of a set may match a lookup, and a second match is flagged as an assertion error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes the pipeline and blocks array reads and fills |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Lookup address `{tag, set}` |
| fill_en | input | 1 | Fill write strobe |
| fill_set | input | IDX_W | Set to fill |
| fill_way | input | WAY_W | Way to fill |
| fill_tag | input | TAG_W | Tag to store |
| fill_vld | input | 1 | Valid bit to store |
| fill_data | input | DATA_W | Data word to store |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Lookup hit |
| res_data | output | DATA_W | Hit data, zero on a miss |

## Verification
A wrong hit vector or a wrong way-select path shows up as a wrong `res_hit` or `res_data` on the very result of the affected lookup, exactly 3 edges (or 2 in two-stage mode) after it was accepted. A lost or doubled pipeline valid flag shows up as a `res_valid` pulse that is missing or out of place in the same window. A fill applied too early or too late, for example a misaligned staged data write in stage-2 launch mode, appears only when a lookup to that set lands within a cycle of the fill. The bench therefore aims same-set lookups at and right after fills, and compares the three build variants against one reference model on every cycle. A valid bit that survives reset produces a false hit on the first lookup to that set after reset.

// File: rtl/cache_lookup_pkg.sv
`timescale 1ns/1ps
package cache_lookup_pkg;

    // Stage in which the speculative data-array read is launched
    typedef enum logic [0:0] {
        LAUNCH_S1 = 1'b0,
        LAUNCH_S2 = 1'b1
    } data_launch_e;

    localparam int unsigned DEF_WAYS   = 4;
    localparam int unsigned DEF_SETS   = 64;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_ADDR_W = 16;

endpackage

// File: rtl/cl_tag_bank.sv
`timescale 1ns/1ps
// Per-way tag arrays with synchronous read plus resettable valid bits.
module cl_tag_bank #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SETS  = 64,
    parameter int unsigned TAG_W = 10,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            rd_set,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        wr_vld,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_vld
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_bits;
        logic [TAG_W-1:0] tag_rd_q;
        logic             vld_rd_q;
        logic             sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        // Read-before-write: a same-cycle read returns the old tag
        always_ff @(posedge clk) begin
            if (rd_en) begin
                tag_rd_q <= tag_mem[rd_set];
            end
            if (sel) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_bits <= '0;
                vld_rd_q <= 1'b0;
            end else begin
                if (rd_en) begin
                    vld_rd_q <= vld_bits[rd_set];
                end
                if (sel) begin
                    vld_bits[wr_set] <= wr_vld;
                end
            end
        end

        assign rd_tag[w] = tag_rd_q;
        assign rd_vld[w] = vld_rd_q;
    end

endmodule

// File: rtl/cl_data_bank.sv
`timescale 1ns/1ps
// Per-way data arrays with synchronous read; all ways read in parallel.
module cl_data_bank #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 64,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rd_en,
    input  logic [IDX_W-1:0]             rd_set,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] dat_mem [SETS];
        logic [DATA_W-1:0] dat_rd_q;

        always_ff @(posedge clk) begin
            if (rd_en) begin
                dat_rd_q <= dat_mem[rd_set];
            end
            if (wr_en && (wr_way == WAY_W'(w))) begin
                dat_mem[wr_set] <= wr_data;
            end
        end

        assign rd_data[w] = dat_rd_q;
    end

endmodule

// File: rtl/cl_tag_match.sv
`timescale 1ns/1ps
// Parallel tag comparators: one hit bit per way.
module cl_tag_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 10
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] && (way_tag[w] == look_tag);
    end

endmodule

// File: rtl/cl_way_select.sv
`timescale 1ns/1ps
// AND-OR way multiplexer driven by a one-hot hit vector; zero on no hit.
module cl_way_select #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [WAYS-1:0]             hit_vec,
    input  logic [WAYS-1:0][DATA_W-1:0] words,
    output logic                        any_hit,
    output logic [DATA_W-1:0]           word
);

    always_comb begin
        word = '0;
        for (int w = 0; w < int'(WAYS); w++) begin
            word = word | ({DATA_W{hit_vec[w]}} & words[w]);
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/pipelined_cache_lookup.sv
`timescale 1ns/1ps
// Pipelined set-associative cache read path: tag read, tag compare, way select.
module pipelined_cache_lookup #(
    parameter int unsigned NUM_WAYS  = cache_lookup_pkg::DEF_WAYS,
    parameter int unsigned NUM_SETS  = cache_lookup_pkg::DEF_SETS,
    parameter int unsigned DATA_W    = cache_lookup_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W    = cache_lookup_pkg::DEF_ADDR_W,
    parameter cache_lookup_pkg::data_launch_e DATA_LAUNCH = cache_lookup_pkg::LAUNCH_S2,
    parameter bit          TWO_STAGE = 1'b0,
    localparam int unsigned IDX_W = $clog2(NUM_SETS),
    localparam int unsigned WAY_W = $clog2(NUM_WAYS),
    localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_set,
    input  logic [WAY_W-1:0]   fill_way,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               fill_vld,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               res_valid,
    output logic               res_hit,
    output logic [DATA_W-1:0]  res_data
);

    // Data read moves to stage 2 only in the three-stage pipeline
    localparam bit LATE_DATA = (DATA_LAUNCH == cache_lookup_pkg::LAUNCH_S2) && !TWO_STAGE;

    typedef struct packed {
        logic                s1_vld;
        logic [ADDR_W-1:0]   s1_addr;
        logic                s2_vld;
        logic [NUM_WAYS-1:0] s2_hitv;
        logic                res_vld;
        logic                res_hit;
        logic [DATA_W-1:0]   res_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // Array interfaces
    logic                              tbank_rd_en;
    logic                              tag_we;
    logic [NUM_WAYS-1:0][TAG_W-1:0]    tag_rd;
    logic [NUM_WAYS-1:0]               vld_rd;
    logic                              dbank_rd_en;
    logic [IDX_W-1:0]                  dbank_rd_set;
    logic                              dbank_wr_en;
    logic [IDX_W-1:0]                  dbank_wr_set;
    logic [WAY_W-1:0]                  dbank_wr_way;
    logic [DATA_W-1:0]                 dbank_wr_data;
    logic [NUM_WAYS-1:0][DATA_W-1:0]   data_rd;
    logic [NUM_WAYS-1:0][DATA_W-1:0]   stage3_words;
    logic [NUM_WAYS-1:0]               hit_vec;
    logic [NUM_WAYS-1:0]               sel_hitv;
    logic [NUM_WAYS-1:0][DATA_W-1:0]   sel_words;
    logic                              sel_hit;
    logic [DATA_W-1:0]                 sel_word;

    assign tbank_rd_en = lk_valid && !stall;
    assign tag_we      = fill_en && !stall;

    cl_tag_bank #(
        .WAYS  (NUM_WAYS),
        .SETS  (NUM_SETS),
        .TAG_W (TAG_W)
    ) tag_bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (tbank_rd_en),
        .rd_set (lk_addr[IDX_W-1:0]),
        .wr_en  (tag_we),
        .wr_set (fill_set),
        .wr_way (fill_way),
        .wr_tag (fill_tag),
        .wr_vld (fill_vld),
        .rd_tag (tag_rd),
        .rd_vld (vld_rd)
    );

    cl_data_bank #(
        .WAYS   (NUM_WAYS),
        .SETS   (NUM_SETS),
        .DATA_W (DATA_W)
    ) data_bank_i (
        .clk     (clk),
        .rd_en   (dbank_rd_en),
        .rd_set  (dbank_rd_set),
        .wr_en   (dbank_wr_en),
        .wr_set  (dbank_wr_set),
        .wr_way  (dbank_wr_way),
        .wr_data (dbank_wr_data),
        .rd_data (data_rd)
    );

    cl_tag_match #(
        .WAYS  (NUM_WAYS),
        .TAG_W (TAG_W)
    ) tag_match_i (
        .way_tag  (tag_rd),
        .way_vld  (vld_rd),
        .look_tag (pipe_q.s1_addr[ADDR_W-1:IDX_W]),
        .hit_vec  (hit_vec)
    );

    // Data-read launch variant
    if (LATE_DATA) begin : g_late
        // The data write is delayed by one stage so that it lines up with the
        // delayed data read; a same-cycle lookup then still sees old data.
        typedef struct packed {
            logic               pend;
            logic [IDX_W-1:0]   set;
            logic [WAY_W-1:0]   way;
            logic [DATA_W-1:0]  data;
        } fill_stage_t;

        fill_stage_t fw_d, fw_q;

        always_comb begin
            fw_d = fw_q;
            if (!stall) begin
                fw_d.pend = fill_en;
                fw_d.set  = fill_set;
                fw_d.way  = fill_way;
                fw_d.data = fill_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fw_q <= '0;
            end else begin
                fw_q <= fw_d;
            end
        end

        assign dbank_rd_en   = pipe_q.s1_vld && !stall;
        assign dbank_rd_set  = pipe_q.s1_addr[IDX_W-1:0];
        assign dbank_wr_en   = fw_q.pend && !stall;
        assign dbank_wr_set  = fw_q.set;
        assign dbank_wr_way  = fw_q.way;
        assign dbank_wr_data = fw_q.data;
        assign stage3_words  = data_rd;
    end else begin : g_early
        assign dbank_rd_en   = tbank_rd_en;
        assign dbank_rd_set  = lk_addr[IDX_W-1:0];
        assign dbank_wr_en   = tag_we;
        assign dbank_wr_set  = fill_set;
        assign dbank_wr_way  = fill_way;
        assign dbank_wr_data = fill_data;

        if (!TWO_STAGE) begin : g_carry
            // Carry the early-read words across the compare stage
            logic [NUM_WAYS-1:0][DATA_W-1:0] carry_d, carry_q;

            always_comb begin
                carry_d = carry_q;
                if (!stall) begin
                    carry_d = data_rd;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    carry_q <= '0;
                end else begin
                    carry_q <= carry_d;
                end
            end

            assign stage3_words = carry_q;
        end else begin : g_nocarry
            assign stage3_words = data_rd;
        end
    end

    // Way-select input variant
    if (TWO_STAGE) begin : g_sel2
        assign sel_hitv  = hit_vec;
        assign sel_words = data_rd;
    end else begin : g_sel3
        assign sel_hitv  = pipe_q.s2_hitv;
        assign sel_words = stage3_words;
    end

    cl_way_select #(
        .WAYS   (NUM_WAYS),
        .DATA_W (DATA_W)
    ) way_select_i (
        .hit_vec (sel_hitv),
        .words   (sel_words),
        .any_hit (sel_hit),
        .word    (sel_word)
    );

    // Next-state computation for every pipeline register
    always_comb begin
        pipe_d = pipe_q;
        if (!stall) begin
            pipe_d.s1_vld  = lk_valid;
            pipe_d.s1_addr = lk_addr;
            if (TWO_STAGE) begin
                pipe_d.res_vld  = pipe_q.s1_vld;
                pipe_d.res_hit  = pipe_q.s1_vld && sel_hit;
                pipe_d.res_data = pipe_q.s1_vld ? sel_word : '0;
            end else begin
                pipe_d.s2_vld   = pipe_q.s1_vld;
                pipe_d.s2_hitv  = pipe_q.s1_vld ? hit_vec : '0;
                pipe_d.res_vld  = pipe_q.s2_vld;
                pipe_d.res_hit  = pipe_q.s2_vld && sel_hit;
                pipe_d.res_data = pipe_q.s2_vld ? sel_word : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign res_valid = pipe_q.res_vld;
    assign res_hit   = pipe_q.res_hit;
    assign res_data  = pipe_q.res_data;

endmodule

// File: rtl/cache_lookup_chk.sv
`timescale 1ns/1ps
// Property checker for the pipelined cache lookup.
module cache_lookup_chk #(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LAT      = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stall,
    input logic                lk_valid,
    input logic                fill_en,
    input logic                tag_we,
    input logic                s1_vld,
    input logic [NUM_WAYS-1:0] hit_vec,
    input logic                res_valid,
    input logic                res_hit,
    input logic [DATA_W-1:0]   res_data
);

    // Accepted-lookup shadow shift register, advances on non-stalled edges
    logic [LAT-1:0] acc_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_sr <= '0;
        end else if (!stall) begin
            acc_sr <= {acc_sr[LAT-2:0], lk_valid};
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == acc_sr[LAT-1])
        else $error("a_r2_latency");

    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_data == '0))
        else $error("a_r3_miss_zero");

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && (res_data == '0)))
        else $error("a_r3_idle_zero");

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(res_valid) && $stable(res_hit) && $stable(res_data)))
        else $error("a_r5_stall_hold");

    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !stall) |=> s1_vld)
        else $error("a_r5_accept");

    a_r5_freeze_s1: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(s1_vld))
        else $error("a_r5_freeze_s1");

    a_r8_no_fill_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && fill_en) |-> !tag_we)
        else $error("a_r8_no_fill_in_stall");

    a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> $onehot0(hit_vec))
        else $error("a_r10_single_match");

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !res_valid)
        else $error("a_r9_reset_clears");

endmodule

bind pipelined_cache_lookup cache_lookup_chk #(
    .NUM_WAYS (NUM_WAYS),
    .DATA_W   (DATA_W),
    .LAT      (TWO_STAGE ? 2 : 3)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .lk_valid  (lk_valid),
    .fill_en   (fill_en),
    .tag_we    (tag_we),
    .s1_vld    (pipe_q.s1_vld),
    .hit_vec   (hit_vec),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_data  (res_data)
);

// File: tb/pipelined_cache_lookup_tb.sv
`timescale 1ns/1ps
module pipelined_cache_lookup_tb_top;

    localparam int WAYS = 4;
    localparam int SETS = 64;
    localparam int DW   = 32;
    localparam int AW   = 16;
    localparam int IW   = 6;
    localparam int WW   = 2;
    localparam int TW   = AW - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          fill_en = 1'b0;
    logic [IW-1:0] fill_set = '0;
    logic [WW-1:0] fill_way = '0;
    logic [TW-1:0] fill_tag = '0;
    logic          fill_vld = 1'b0;
    logic [DW-1:0] fill_data = '0;

    logic          rv0, rh0, rv1, rh1, rv2, rh2;
    logic [DW-1:0] rd0, rd1, rd2;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // Default build: data read launched in stage 2, three stages
    pipelined_cache_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_vld(fill_vld), .fill_data(fill_data),
        .res_valid(rv0), .res_hit(rh0), .res_data(rd0)
    );

    pipelined_cache_lookup #(.DATA_LAUNCH(cache_lookup_pkg::LAUNCH_S1)) dut_s1_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_vld(fill_vld), .fill_data(fill_data),
        .res_valid(rv1), .res_hit(rh1), .res_data(rd1)
    );

    pipelined_cache_lookup #(.DATA_LAUNCH(cache_lookup_pkg::LAUNCH_S1), .TWO_STAGE(1'b1)) dut_two_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_vld(fill_vld), .fill_data(fill_data),
        .res_valid(rv2), .res_hit(rh2), .res_data(rd2)
    );

    // Reference model state
    logic [TW-1:0] sh_tag [WAYS][SETS];
    logic          sh_vld [WAYS][SETS];
    logic [DW-1:0] sh_dat [WAYS][SETS];

    typedef struct packed {
        logic          v;
        logic          h;
        logic [DW-1:0] d;
    } res_t;

    res_t p3 [3];
    res_t p2 [2];

    function automatic res_t model_lookup(input logic [AW-1:0] a);
        res_t r;
        r = '0;
        r.v = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (sh_vld[w][a[IW-1:0]] && sh_tag[w][a[IW-1:0]] == a[AW-1:IW]) begin
                r.h = 1'b1;
                r.d = sh_dat[w][a[IW-1:0]];
            end
        end
        return r;
    endfunction

    // Tags carry the way number in their low bits so no set ever holds a tag twice
    function automatic logic [TW-1:0] fill_tag_for(input int way);
        return TW'((($urandom % 4) << 2) | way);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++)
                sh_vld[w][s] = 1'b0;
        for (int i = 0; i < 3; i++) p3[i] = '0;
        for (int i = 0; i < 2; i++) p2[i] = '0;
    endtask

    // One clock cycle with the inputs currently driven, then per-cycle checks
    task automatic cyc();
        res_t r;
        if (!stall) begin
            r = lk_valid ? model_lookup(lk_addr) : '0;
            p3[2] = p3[1]; p3[1] = p3[0]; p3[0] = r;
            p2[1] = p2[0]; p2[0] = r;
            if (fill_en) begin
                sh_tag[fill_way][fill_set] = fill_tag;
                sh_vld[fill_way][fill_set] = fill_vld;
                sh_dat[fill_way][fill_set] = fill_data;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2 valid three-stage", DW'(rv0), DW'(p3[2].v));
        chk("R1 hit", DW'(rh0), DW'(p3[2].h));
        chk("R3 data", rd0, p3[2].d);
        chk("R4 stage-1 launch valid", DW'(rv1), DW'(p3[2].v));
        chk("R4 stage-1 launch hit", DW'(rh1), DW'(rh0));
        chk("R4 stage-1 launch data", rd1, rd0);
        chk("R2 valid two-stage", DW'(rv2), DW'(p2[1].v));
        chk("R1 hit two-stage", DW'(rh2), DW'(p2[1].h));
        chk("R3 data two-stage", rd2, p2[1].d);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; stall = 1'b0; lk_valid = 1'b0; fill_en = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        chk("R9 reset valid", DW'(rv0), 0);
        chk("R9 reset hit", DW'(rh0), 0);
        chk("R9 reset data", rd0, 0);
        chk("R9 reset valid stage-1 launch", DW'(rv1), 0);
        chk("R9 reset valid two-stage", DW'(rv2), 0);
        rst_n = 1'b1;
    endtask

    task automatic do_fill(input int set, input int way, input logic [TW-1:0] tag,
                           input logic vld, input logic [DW-1:0] data);
        fill_en = 1'b1; fill_set = IW'(set); fill_way = WW'(way);
        fill_tag = tag; fill_vld = vld; fill_data = data;
        cyc();
        fill_en = 1'b0;
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic eh, input logic [DW-1:0] ed,
                         input string req);
        lk_valid = 1'b1; lk_addr = a;
        cyc();
        lk_valid = 1'b0;
        cyc();
        cyc();
        chk({req, " hit"}, DW'(rh0), DW'(eh));
        chk({req, " data"}, rd0, ed);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] snap_d;
        logic          snap_v, snap_h;
        int            seed;
        seed = $urandom(32'd20240611);
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) begin
                sh_tag[w][s] = '0;
                sh_dat[w][s] = '0;
            end
        do_reset();

        // R9: nothing valid after reset
        probe({10'h005, 6'd3}, 1'b0, '0, "R9 miss after reset");

        // R6, R1: fill then hit
        do_fill(3, 1, 10'h005, 1'b1, 32'hCAFE_0031);
        probe({10'h005, 6'd3}, 1'b1, 32'hCAFE_0031, "R6 fill visible");
        probe({10'h009, 6'd3}, 1'b0, '0, "R1 tag mismatch");

        // R7: same-cycle fill and lookup of one set sees old contents
        fill_en = 1'b1; fill_set = 6'd9; fill_way = 2'd2; fill_tag = 10'h00A;
        fill_vld = 1'b1; fill_data = 32'h1234_0092;
        lk_valid = 1'b1; lk_addr = {10'h00A, 6'd9};
        cyc();
        fill_en = 1'b0;
        cyc();
        lk_valid = 1'b0;
        cyc();
        chk("R7 same-cycle old contents hit", DW'(rh0), 0);
        cyc();
        chk("R6 next-cycle new contents hit", DW'(rh0), 1);
        chk("R6 next-cycle new contents data", rd0, 32'h1234_0092);

        // R8: fill under stall is ignored
        stall = 1'b1;
        do_fill(12, 0, 10'h010, 1'b1, 32'hDEAD_0120);
        stall = 1'b0;
        probe({10'h010, 6'd12}, 1'b0, '0, "R8 stalled fill ignored");

        // R10: invalidating fill
        do_fill(3, 1, 10'h005, 1'b0, 32'h0);
        probe({10'h005, 6'd3}, 1'b0, '0, "R10 invalidated way misses");

        // R5: stall with lookups in flight, new lookups dropped
        do_fill(20, 3, 10'h007, 1'b1, 32'hA0A0_0203);
        do_fill(21, 0, 10'h00C, 1'b1, 32'hB0B0_0210);
        lk_valid = 1'b1; lk_addr = {10'h007, 6'd20}; cyc();
        lk_addr = {10'h00C, 6'd21}; cyc();
        lk_addr = {10'h007, 6'd20}; cyc();
        snap_v = rv0; snap_h = rh0; snap_d = rd0;
        stall = 1'b1;
        lk_addr = {10'h00C, 6'd21};
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R5 stall holds valid", DW'(rv0), DW'(snap_v));
            chk("R5 stall holds hit", DW'(rh0), DW'(snap_h));
            chk("R5 stall holds data", rd0, snap_d);
        end
        stall = 1'b0;
        lk_valid = 1'b0;
        cyc();
        chk("R5 in-flight result after stall", rd0, 32'hB0B0_0210);
        cyc();
        chk("R5 in-flight result after stall", rd0, 32'hA0A0_0203);
        cyc();
        chk("R5 stalled request dropped", DW'(rv0), 0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int way;
            stall    = (($urandom % 8) == 0);
            fill_en  = (($urandom % 4) == 0);
            way      = int'($urandom % WAYS);
            fill_way = WW'(way);
            fill_set = IW'($urandom % 8);
            fill_tag = fill_tag_for(way);
            fill_vld = (($urandom % 8) != 0);
            fill_data = $urandom;
            lk_valid = (($urandom % 4) != 0);
            if (($urandom % 16) == 0)
                lk_addr = AW'($urandom);
            else
                lk_addr = {TW'((($urandom % 4) << 2) | ($urandom % 4)), IW'($urandom % 8)};
            cyc();
        end
        stall = 1'b0; fill_en = 1'b0; lk_valid = 1'b0;
        repeat (3) cyc();

        // R9: mid-run reset drops every valid bit
        do_fill(40, 2, 10'h00E, 1'b1, 32'h5555_0402);
        do_reset();
        probe({10'h00E, 6'd40}, 1'b0, '0, "R9 valid bits cleared by reset");
        do_fill(40, 2, 10'h00E, 1'b1, 32'h6666_0402);
        probe({10'h00E, 6'd40}, 1'b1, 32'h6666_0402, "R6 fill after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule